// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block turns a single access request from core logic into one complete bus cycle on a time-multiplexed external bus. The same sixteen lines carry the low address in the first clock and data afterwards. Four upper lines carry the top address bits first and then a status word. The high-byte enable pin likewise switches from its enable meaning to a fixed status bit. The sequencer generates the address latch pulse, the read and write strobes, the data-enable and direction controls for external transceivers, and the memory/I-O select.

Each accepted request runs a phase sequence: address, strobe, ready sample with optional wait clocks, then release. A slow device stretches the cycle by holding `ready` low. An external bus master can take the bus with `hold`. The sequencer completes any cycle in progress, acknowledges, and drops its output enable so that the pads float. The pads, latches and transceivers sit outside the block. The tri-state condition is presented as the enables `busOe` (all driven pins) and `adOe` (the address/data lines). Misaligned words are split by the core, so every request is one aligned access.

Top module: `mux_bus_cycler`

## Requirements
- R1: An accepted request gives `ale` high for exactly one clock, the first clock of the cycle. In that clock `adOut` equals address bits 15..0 with `adOe` high, and `hiOut` equals address bits 19..16.
- R2: From the second clock to the end of the cycle, `hiOut` carries status. Bits [1:0] hold the segment code (00 extra, 01 stack, 10 code, 11 data), and an I/O request always shows 10. Bit [2] holds `ieFlag` as sampled at acceptance. Bit [3] is 0.
- R3: In the first clock `bheN` is 0 when the request is a word or address bit 0 is 1, and 1 otherwise. A word at an odd address is therefore driven as an odd-byte transfer. From the second clock `bheN` is 1.
- R4: Throughout the cycle `mio` is 1 for memory and 0 for I/O, and `dtR` is 1 for a write and 0 for a read.
- R5: For a read, `adOe` is 0 from the second clock to the end of the cycle. For a write, `adOut` carries the write data from the second clock on.
- R6: From the second clock through the last clock in which `ready` is sampled, `denN` is 0 and exactly one strobe is 0: `rdN` for a read, `wrN` for a write. The two strobes are never low together.
- R7: `ready` is sampled in the third clock and in every wait clock. Each low sample adds one wait clock with the strobes held, so a cycle lasts 4 + (low samples) clocks, with `busy` high in each of them.
- R8: In the final clock both strobes and `denN` are high and `doneP` is high for that clock only. After a read, `rdData` holds the `adIn` value present at the edge that entered that clock.
- R9: When `hold` is high in an idle clock, or during the final clock of a cycle, the next clock shows `holdAck` 1 with `busOe` and `adOe` 0. A cycle in progress is never cut short. `hold` wins over a request presented in the same idle clock.
- R10: While `holdAck` is high, requests are not accepted (`busy` and `ale` stay 0). After `hold` falls, `holdAck` is 0 in the next clock, and a waiting request starts its first clock one clock later.
- R11: During and straight after reset the block is idle: `ale`, `busy`, `doneP`, `holdAck` are 0, and `rdN`, `wrN`, `denN`, `busOe` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request, taken when idle and not held |
| reqWrite | input | 1 | 1 write, 0 read |
| reqMem | input | 1 | 1 memory, 0 I/O |
| reqWord | input | 1 | 1 word, 0 byte |
| reqAddr | input | 20 | Physical address |
| reqSeg | input | 2 | Segment code of the access |
| reqWdata | input | 16 | Write data |
| ieFlag | input | 1 | Interrupt-enable flag for status |
| ready | input | 1 | Device ready, low inserts waits |
| hold | input | 1 | Bus request from another master |
| adIn | input | 16 | Value seen on the address/data pads |
| adOut | output | 16 | Address then data to the pads |
| adOe | output | 1 | Drive enable for the address/data pads |
| hiOut | output | 4 | Upper address then status |
| bheN | output | 1 | High-byte enable (low), later status 1 |
| ale | output | 1 | Address latch pulse |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| denN | output | 1 | Transceiver enable, active low |
| dtR | output | 1 | Transceiver direction, 1 transmit |
| mio | output | 1 | 1 memory, 0 I/O |
| busOe | output | 1 | Drive enable for status, strobes and select |
| holdAck | output | 1 | Bus released to another master |
| busy | output | 1 | A cycle is in progress |
| doneP | output | 1 | Final clock of a cycle |
| rdData | output | 16 | Captured read data |

## Verification
A wrong phase state appears at the pads within one clock. A misplaced `ale`, a strobe that is late or early, or a status word shown during the address clock all break the phase-by-phase comparison in that same clock. A miscounted wait shows as `doneP` arriving one clock early or late against the bench's ready pattern. A hold handshake that is entered at the wrong point shows either as `holdAck` rising while strobes are still active or as `busOe` staying high for a clock after the grant.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_T1,
    ST_T2,
    ST_T3,
    ST_TW,
    ST_T4,
    ST_HOLD
  } busSt_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;       // latch the incoming request
    logic addrPhase;  // first clock of the cycle
    logic dataPhase;  // second clock to final clock
    logic capture;    // sample read data
  } dpCtl_t;

  localparam logic [1:0] SEG_EXTRA = 2'b00;
  localparam logic [1:0] SEG_STACK = 2'b01;
  localparam logic [1:0] SEG_CODE  = 2'b10;
  localparam logic [1:0] SEG_DATA  = 2'b11;

endpackage

// File: rtl/mbc_dp.sv
module mbc_dp
  import mbc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              reqWrite,
  input  logic              reqMem,
  input  logic              reqWord,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSeg,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              ieFlag,
  input  logic [DATA_W-1:0] adIn,
  output logic              curWrite,
  output logic [DATA_W-1:0] adOut,
  output logic [ADDR_W-DATA_W-1:0] hiOut,
  output logic              bheN,
  output logic              mio,
  output logic [DATA_W-1:0] rdData
);

  localparam int HI_W = ADDR_W - DATA_W;

  logic              rWrite, rMem, rWord, rIe;
  logic [ADDR_W-1:0] rAddr;
  logic [1:0]        rSeg;
  logic [DATA_W-1:0] rWdata;
  logic [HI_W-1:0]   statusWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rWrite <= 1'b0;
      rMem   <= 1'b1;
      rWord  <= 1'b0;
      rIe    <= 1'b0;
      rAddr  <= '0;
      rSeg   <= SEG_EXTRA;
      rWdata <= '0;
    end else if (ctl.load) begin
      rWrite <= reqWrite;
      rMem   <= reqMem;
      rWord  <= reqWord;
      rIe    <= ieFlag;
      rAddr  <= reqAddr;
      rSeg   <= reqMem ? reqSeg : SEG_CODE;
      rWdata <= reqWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else if (ctl.capture && !rWrite) rdData <= adIn;
  end

  always_comb begin
    statusWord      = '0;
    statusWord[1:0] = rSeg;
    statusWord[2]   = rIe;
  end

  always_comb begin
    if (ctl.addrPhase) begin
      adOut = rAddr[DATA_W-1:0];
      hiOut = rAddr[ADDR_W-1:DATA_W];
      bheN  = ~(rWord | rAddr[0]);
    end else if (ctl.dataPhase) begin
      adOut = rWdata;
      hiOut = statusWord;
      bheN  = 1'b1;
    end else begin
      adOut = '0;
      hiOut = '0;
      bheN  = 1'b1;
    end
  end

  assign mio      = rMem;
  assign curWrite = rWrite;

endmodule

// File: rtl/mbc_ctrl.sv
module mbc_ctrl
  import mbc_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   ready,
  input  logic   hold,
  input  logic   curWrite,
  output dpCtl_t ctl,
  output logic   ale,
  output logic   rdN,
  output logic   wrN,
  output logic   denN,
  output logic   dtR,
  output logic   adOe,
  output logic   busOe,
  output logic   holdAck,
  output logic   busy,
  output logic   doneP
);

  busSt_t state, stateNext;
  logic   strobeWin, inCycle, waitPhase;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (hold)          stateNext = ST_HOLD;
        else if (reqValid) stateNext = ST_T1;
      end
      ST_T1:   stateNext = ST_T2;
      ST_T2:   stateNext = ST_T3;
      ST_T3,
      ST_TW:   stateNext = ready ? ST_T4 : ST_TW;
      ST_T4:   stateNext = hold ? ST_HOLD : ST_IDLE;
      ST_HOLD: if (!hold) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign waitPhase = (state == ST_T3) || (state == ST_TW);
  assign strobeWin = (state == ST_T2) || waitPhase;
  assign inCycle   = (state == ST_T1) || strobeWin || (state == ST_T4);

  always_comb begin
    ctl.load      = (state == ST_IDLE) && !hold && reqValid;
    ctl.addrPhase = (state == ST_T1);
    ctl.dataPhase = strobeWin || (state == ST_T4);
    ctl.capture   = waitPhase && ready;
  end

  assign ale     = (state == ST_T1);
  assign rdN     = ~(strobeWin && !curWrite);
  assign wrN     = ~(strobeWin && curWrite);
  assign denN    = ~strobeWin;
  assign dtR     = inCycle ? curWrite : 1'b1;
  assign busOe   = (state != ST_HOLD);
  assign adOe    = busOe && !(ctl.dataPhase && !curWrite);
  assign holdAck = (state == ST_HOLD);
  assign busy    = inCycle;
  assign doneP   = (state == ST_T4);

endmodule

// File: rtl/mux_bus_cycler.sv
module mux_bus_cycler
  import mbc_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  input  logic                     reqWrite,
  input  logic                     reqMem,
  input  logic                     reqWord,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [1:0]               reqSeg,
  input  logic [DATA_W-1:0]        reqWdata,
  input  logic                     ieFlag,
  input  logic                     ready,
  input  logic                     hold,
  input  logic [DATA_W-1:0]        adIn,
  output logic [DATA_W-1:0]        adOut,
  output logic                     adOe,
  output logic [ADDR_W-DATA_W-1:0] hiOut,
  output logic                     bheN,
  output logic                     ale,
  output logic                     rdN,
  output logic                     wrN,
  output logic                     denN,
  output logic                     dtR,
  output logic                     mio,
  output logic                     busOe,
  output logic                     holdAck,
  output logic                     busy,
  output logic                     doneP,
  output logic [DATA_W-1:0]        rdData
);

  dpCtl_t ctl;
  logic   curWrite;

  mbc_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .ready(ready), .hold(hold),
    .curWrite(curWrite), .ctl(ctl), .ale(ale), .rdN(rdN), .wrN(wrN),
    .denN(denN), .dtR(dtR), .adOe(adOe), .busOe(busOe), .holdAck(holdAck),
    .busy(busy), .doneP(doneP)
  );

  mbc_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqWrite(reqWrite), .reqMem(reqMem),
    .reqWord(reqWord), .reqAddr(reqAddr), .reqSeg(reqSeg), .reqWdata(reqWdata),
    .ieFlag(ieFlag), .adIn(adIn), .curWrite(curWrite), .adOut(adOut),
    .hiOut(hiOut), .bheN(bheN), .mio(mio), .rdData(rdData)
  );

endmodule

// File: rtl/mbc_checker.sv
module mbc_checker (
  input logic clk,
  input logic rstN,
  input logic ready,
  input logic ale,
  input logic rdN,
  input logic wrN,
  input logic bheN,
  input logic adOe,
  input logic busOe,
  input logic holdAck,
  input logic busy,
  input logic doneP
);

  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rstN) ale |=> !ale); // R1
  AST_BHE_STATUS: assert property (@(posedge clk) disable iff (!rstN) !rdN |-> bheN); // R3
  AST_READ_FLOAT: assert property (@(posedge clk) disable iff (!rstN) !rdN |-> !adOe); // R5
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN) !(!rdN && !wrN)); // R6
  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rstN) (!rdN && !ready) |=> !rdN); // R7
  AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rstN) $rose(doneP) |-> $past(!rdN || !wrN)); // R8
  AST_HOLD_FLOAT: assert property (@(posedge clk) disable iff (!rstN) holdAck |-> (!busOe && !adOe)); // R9
  AST_HOLD_NOT_MIDCYCLE: assert property (@(posedge clk) disable iff (!rstN) busy |-> !holdAck); // R10

endmodule

bind mux_bus_cycler mbc_checker i_chk (
  .clk(clk), .rstN(rstN), .ready(ready), .ale(ale), .rdN(rdN), .wrN(wrN),
  .bheN(bheN), .adOe(adOe), .busOe(busOe), .holdAck(holdAck), .busy(busy),
  .doneP(doneP)
);

// File: tb/test_mux_bus_cycler.sv
module test_mux_bus_cycler;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqMem = 1'b1, reqWord = 1'b0;
  logic [19:0] reqAddr = '0;
  logic [1:0]  reqSeg = '0;
  logic [15:0] reqWdata = '0;
  logic        ieFlag = 1'b0, ready = 1'b1, hold = 1'b0;
  logic [15:0] adIn = '0;
  logic [15:0] adOut, rdData;
  logic [3:0]  hiOut;
  logic        adOe, bheN, ale, rdN, wrN, denN, dtR, mio, busOe, holdAck, busy, doneP;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mux_bus_cycler i_mux_bus_cycler (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqMem(reqMem), .reqWord(reqWord), .reqAddr(reqAddr), .reqSeg(reqSeg),
    .reqWdata(reqWdata), .ieFlag(ieFlag), .ready(ready), .hold(hold),
    .adIn(adIn), .adOut(adOut), .adOe(adOe), .hiOut(hiOut), .bheN(bheN),
    .ale(ale), .rdN(rdN), .wrN(wrN), .denN(denN), .dtR(dtR), .mio(mio),
    .busOe(busOe), .holdAck(holdAck), .busy(busy), .doneP(doneP), .rdData(rdData)
  );

  typedef struct packed {
    logic        wr;
    logic        mem;
    logic        word;
    logic [19:0] addr;
    logic [1:0]  seg;
    logic        ie;
    logic [3:0]  waits;
    logic [15:0] data;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b1, 1'b1, 20'h12344, 2'b11, 1'b1, 4'd0, 16'hBEEF},
    '{1'b1, 1'b1, 1'b0, 20'hABCD1, 2'b01, 1'b0, 4'd2, 16'h5A5A},
    '{1'b0, 1'b1, 1'b0, 20'h00F00, 2'b00, 1'b1, 4'd1, 16'h1234},
    '{1'b1, 1'b0, 1'b1, 20'h00040, 2'b11, 1'b0, 4'd0, 16'hC3C3},
    '{1'b0, 1'b0, 1'b0, 20'h00029, 2'b01, 1'b1, 4'd3, 16'h7E81},
    '{1'b0, 1'b1, 1'b1, 20'h20003, 2'b10, 1'b0, 4'd0, 16'h0F0F}
  };

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] expStat(vec_t v);
    logic [1:0] s;
    s = v.mem ? v.seg : 2'b10;   // R2: I/O shows code segment
    return {1'b0, v.ie, s};
  endfunction

  function automatic logic [2:0] expStrobes(logic wr);
    return wr ? 3'b100 : 3'b010;   // {rdN, wrN, denN}
  endfunction

  task automatic runCycle(input vec_t v);
    reqWrite = v.wr; reqMem = v.mem; reqWord = v.word; reqAddr = v.addr;
    reqSeg = v.seg; ieFlag = v.ie; reqWdata = v.data; adIn = v.data;
    ready = 1'b0; reqValid = 1'b1;
    @(negedge clk);  // T1
    reqValid = 1'b0;
    chk(ale && adOe && adOut == v.addr[15:0], "R1 ale/low address", {15'd0, ale, adOut}, {16'd1, v.addr[15:0]});
    chk(hiOut == v.addr[19:16], "R1 upper address", hiOut, v.addr[19:16]);
    chk(bheN == ~(v.word | v.addr[0]), "R3 byte enable", bheN, ~(v.word | v.addr[0]));
    chk(mio == v.mem && dtR == v.wr, "R4 select/direction", {mio, dtR}, {v.mem, v.wr});
    chk({rdN, wrN, denN} == 3'b111 && busy, "R7 T1 strobes idle, busy", {busy, rdN, wrN, denN}, 4'b1111);
    @(negedge clk);  // T2
    chk(!ale && hiOut == expStat(v), "R2 status word", {ale, hiOut}, {1'b0, expStat(v)});
    chk(bheN == 1'b1, "R3 status bit after address", bheN, 1);
    chk({rdN, wrN, denN} == expStrobes(v.wr), "R6 strobes in T2", {rdN, wrN, denN}, expStrobes(v.wr));
    if (v.wr) chk(adOe && adOut == v.data, "R5 write data driven", {adOe, adOut}, {1'b1, v.data});
    else      chk(!adOe, "R5 read bus released", adOe, 0);
    @(negedge clk);  // T3
    ready = (v.waits == 0);
    chk({rdN, wrN, denN} == expStrobes(v.wr) && !doneP, "R6 strobes in T3", {doneP, rdN, wrN, denN}, {1'b0, expStrobes(v.wr)});
    for (int j = 1; j <= int'(v.waits); j++) begin
      @(negedge clk);  // TW
      ready = (j == int'(v.waits));
      chk({rdN, wrN, denN} == expStrobes(v.wr) && !doneP && busy, "R7 wait clock held", {doneP, rdN, wrN, denN}, {1'b0, expStrobes(v.wr)});
    end
    @(negedge clk);  // T4
    ready = 1'b1;
    chk(doneP && {rdN, wrN, denN} == 3'b111, "R8 final clock", {doneP, rdN, wrN, denN}, 4'b1111);
    chk(hiOut == expStat(v) && mio == v.mem && dtR == v.wr, "R4 select held to end", {hiOut, mio, dtR}, {expStat(v), v.mem, v.wr});
    if (!v.wr) chk(rdData == v.data, "R8 read data", rdData, v.data);
    @(negedge clk);  // idle
    chk(!doneP && !busy, "R8 done single clock", {doneP, busy}, 0);
  endtask

  initial begin
    #4_000_000;
    chk(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk({ale, busy, doneP, holdAck} == 4'b0 && {rdN, wrN, denN, busOe} == 4'hF,
        "R11 reset state", {ale, busy, doneP, holdAck, rdN, wrN, denN, busOe}, 8'h0F);
    rstN = 1'b1;
    @(negedge clk);
    chk({ale, busy, doneP, holdAck} == 4'b0 && {rdN, wrN, denN, busOe} == 4'hF,
        "R11 idle after reset", {ale, busy, doneP, holdAck, rdN, wrN, denN, busOe}, 8'h0F);

    for (int i = 0; i < NVEC; i++) runCycle(VECS[i]);

    // R9/R10: hold in idle beats a simultaneous request
    reqWrite = 1'b0; reqMem = 1'b1; reqWord = 1'b1; reqAddr = 20'h55554;
    reqSeg = 2'b11; adIn = 16'hA5A5; hold = 1'b1; reqValid = 1'b1;
    @(negedge clk);
    chk(holdAck && !busOe && !adOe, "R9 hold from idle", {holdAck, busOe, adOe}, 3'b100);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!busy && !ale && holdAck, "R10 request ignored in hold", {busy, ale, holdAck}, 3'b001);
    end
    hold = 1'b0;
    @(negedge clk);
    chk(!holdAck && busOe && !ale, "R10 release hold", {holdAck, busOe, ale}, 3'b010);
    @(negedge clk);
    chk(ale && adOut == 16'h5554, "R10 pending request starts", {15'd0, ale, adOut}, {16'd1, 16'h5554});
    reqValid = 1'b0;
    @(negedge clk);  // T2
    @(negedge clk);  // T3
    ready = 1'b1;
    @(negedge clk);  // T4
    chk(doneP && rdData == 16'hA5A5, "R8 read after hold", {15'd0, doneP, rdData}, {16'd1, 16'hA5A5});
    @(negedge clk);

    // R9: hold raised mid-cycle is deferred to the end of the cycle
    reqWrite = 1'b1; reqWdata = 16'h3C3C; ready = 1'b0; reqValid = 1'b1;
    @(negedge clk);  // T1
    reqValid = 1'b0;
    @(negedge clk);  // T2
    hold = 1'b1;
    chk(!holdAck && !wrN, "R9 no grant in strobe", {holdAck, wrN}, 2'b00);
    @(negedge clk);  // T3
    ready = 1'b1;
    chk(!holdAck && busOe && !wrN, "R9 cycle continues", {holdAck, busOe, wrN}, 3'b010);
    @(negedge clk);  // T4
    chk(doneP && !holdAck, "R9 cycle completes before grant", {doneP, holdAck}, 2'b10);
    @(negedge clk);
    chk(holdAck && !busOe && !adOe, "R9 grant after cycle", {holdAck, busOe, adOe}, 3'b100);
    hold = 1'b0;
    @(negedge clk);
    chk(!holdAck && busOe, "R10 hold dropped", {holdAck, busOe}, 2'b01);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule